// File: doc/BRIEF.md
# Break-Before-Make Channel Select Controller

This block drives the switch enables of a sixteen-way analog multiplexer from a 4-bit channel address. It turns the address into sixteen one-hot enables plus one enable for the common output. Whenever the selected channel changes, every switch is first opened for a break interval, and only then does the new switch close. Two inputs can never be shorted together during a transition.

A parameter selects how the address is taken in. In gated mode the address pins are followed while an active-low chip select is low. A change is taken only after a skew window, so the bits of one change may arrive at slightly different times. In strobe mode the pins are sampled once, on each rising edge of a latch strobe. All inputs pass through two-stage synchronizers. Every delay is counted in cycles of the system clock.

The common output stays off while the asynchronous active-low reset is held. It comes up on channel 0 once reset is released.

Top module: `bbm_chan_sel`

## Requirements
- R1: The address is decoded in plain binary: an applied address n (0 to 15) drives `sw_en` to the value with only bit n set.
- R2: A new channel enable rises only after a clock cycle in which all sixteen enables were low.
- R3: After an accepted change, all enables stay low for at least BREAK_CYC clock cycles before the new enable rises.
- R4: In gated mode (STROBE_MODE=0), address changes are ignored while `cs_n` is high and the last accepted channel stays enabled. A change is taken once `cs_n` is low.
- R5: In gated mode, when the bits of one change arrive within SKEW_CYC cycles of the first bit change, only the final address is ever enabled.
- R6: In strobe mode (STROBE_MODE=1), the address is sampled only on a rising edge of `stb`. Pin changes made while `stb` is held high or low have no effect.
- R7: While `rst_n` is low, `sw_en` is all zero and `com_en` is low, whatever the clock does.
- R8: On the first clock edge after `rst_n` goes high, `com_en` rises and `sw_en` selects channel 0.
- R9: If a further change is accepted while a break interval is running, the interval restarts and only the latest address is enabled.
- R10: At no clock edge are two bits of `sw_en` high together.
- R11: `busy` is high from an accepted change until the new channel enable rises, and low otherwise.
- R12: A pin change that is accepted drives the new enable no later than 3+SKEW_CYC+BREAK_CYC clock edges after the change in gated mode. In strobe mode the bound is 3+BREAK_CYC edges after the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select (gated mode) |
| stb | input | 1 | Latch strobe, sampled on its rising edge (strobe mode) |
| addr | input | 4 | Channel address |
| sw_en | output | 16 | One-hot switch enables; bit n closes channel n |
| com_en | output | 1 | Common output enable; low means high impedance |
| busy | output | 1 | A channel change is in progress |

## Verification
The bench aims at transitions that could let two switches overlap or close too early. It looks for an enable that moves straight from one channel to another with no all-off cycle, and for a break shorter than BREAK_CYC. A design that took the first bit of a skewed change, or that finished a break after a newer address arrived, would briefly enable a channel that was never meant to be selected. The scoreboard sees that as an unexpected item. The bench also holds chip select high and the strobe steady while it moves the pins: a leaky gate would switch channels there. Finally, it resets in mid-run to catch an output that stays on, or that comes up on a channel other than 0.

// File: rtl/bbm_chan_sel.sv
module bbm_chan_sel #(
  parameter int AW          = 4,
  parameter bit STROBE_MODE = 1'b0,
  parameter int SKEW_CYC    = 2,
  parameter int BREAK_CYC   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 stb,
  input  logic [AW-1:0]        addr,
  output logic [(1<<AW)-1:0]   sw_en,
  output logic                 com_en,
  output logic                 busy
);
  localparam int NCH  = 1 << AW;
  localparam int MAXC = (SKEW_CYC > BREAK_CYC) ? SKEW_CYC : BREAK_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SKEW, S_BREAK} st_t;

  logic [AW-1:0] a_s1, a_s2, tgt;
  logic          cs1, cs2, st1, st2, st3;
  logic [CW-1:0] cnt;
  st_t           st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_s1 <= '0; a_s2 <= '0;
      cs1 <= 1'b1; cs2 <= 1'b1;
      st1 <= 1'b0; st2 <= 1'b0; st3 <= 1'b0;
    end else begin
      a_s1 <= addr; a_s2 <= a_s1;
      cs1 <= cs_n;  cs2 <= cs1;
      st1 <= stb;   st2 <= st1; st3 <= st2;
    end
  end

  wire differs  = (a_s2 != tgt);
  wire gate_ok  = STROBE_MODE ? (st2 & ~st3) : ~cs2;
  wire open_now = ~|sw_en;

  assign busy = com_en & open_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt    <= '0;
      sw_en  <= '0;
      com_en <= 1'b0;
      st     <= S_IDLE;
      cnt    <= '0;
    end else if (!com_en) begin
      com_en <= 1'b1;
      sw_en  <= NCH'(1);
    end else if (STROBE_MODE) begin
      if (gate_ok && differs) begin
        tgt   <= a_s2;
        sw_en <= '0;
        st    <= S_BREAK;
        cnt   <= CW'(BREAK_CYC - 1);
      end else if (st == S_BREAK) begin
        if (cnt == '0) begin
          sw_en <= NCH'(1) << tgt;
          st    <= S_IDLE;
        end else cnt <= cnt - 1'b1;
      end
    end else begin
      case (st)
        S_SKEW: begin
          if (!gate_ok || cnt == '0) begin
            if (gate_ok && differs) begin
              tgt   <= a_s2;
              sw_en <= '0;
            end
            if ((gate_ok && differs) || open_now) begin
              st  <= S_BREAK;
              cnt <= CW'(BREAK_CYC - 1);
            end else st <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: begin
          if (gate_ok && differs) begin
            st  <= S_SKEW;
            cnt <= CW'(SKEW_CYC - 1);
          end else if (st == S_BREAK) begin
            if (cnt == '0) begin
              sw_en <= NCH'(1) << tgt;
              st    <= S_IDLE;
            end else cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  logic [15:0] off_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_run <= '0;
    else if (com_en && open_now) off_run <= (off_run == 16'hFFFF) ? off_run : off_run + 1'b1;
    else off_run <= '0;
  end

  assert_one_hot_R10: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sw_en));

  assert_break_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_en && sw_en != $past(sw_en)) |-> ($past(sw_en) == '0));

  assert_break_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (com_en && $past(com_en) && |sw_en && $past(sw_en) == '0) |-> ($past(off_run) >= 16'(BREAK_CYC - 1)));

  assert_wake_ch0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(com_en) |-> (sw_en == NCH'(1)));

  always @(negedge clk)
    if (!rst_n) assert_reset_off_R7: assert (sw_en == '0 && !com_en && !busy);
endmodule

// File: tb/tb_bbm_chan_sel.sv
module tb_bbm_chan_sel;
  localparam int PERIOD = 10;
  localparam int SKEW   = 2;
  localparam int BRK    = 6;
  localparam int WAIT_G = 3 + SKEW + BRK;
  localparam int WAIT_S = 3 + BRK;

  logic clk = 1'b0;
  logic rst_n, cs_n, stb, s_stb;
  logic [3:0] addr, s_addr;
  logic [15:0] sw_en, s_sw;
  logic com_en, busy, s_com, s_busy;

  int errors = 0, checks = 0;
  int q[$];
  bit done = 1'b0;
  int cur = 0;

  always #(PERIOD/2) clk = ~clk;

  bbm_chan_sel #(.AW(4), .STROBE_MODE(1'b0), .SKEW_CYC(SKEW), .BREAK_CYC(BRK)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .stb(stb), .addr(addr),
    .sw_en(sw_en), .com_en(com_en), .busy(busy));

  bbm_chan_sel #(.AW(4), .STROBE_MODE(1'b1), .SKEW_CYC(SKEW), .BREAK_CYC(BRK)) dut_stb (
    .clk(clk), .rst_n(rst_n), .cs_n(1'b1), .stb(s_stb), .addr(s_addr),
    .sw_en(s_sw), .com_en(s_com), .busy(s_busy));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply(input int a);
    addr = 4'(a);
    if (a != cur) q.push_back(a);
    cur = a;
    repeat (WAIT_G) @(negedge clk);
    chk(sw_en == (16'd1 << a), "R1/R12 gated decode", sw_en, 16'd1 << a);
  endtask

  // scoreboard monitor for the gated instance
  logic [15:0] prev_sw;
  bit prev_com;
  int off;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sw = '0; prev_com = 1'b0; off = 0;
    end else begin
      chk($countones(sw_en) <= 1 && $countones(s_sw) <= 1, "R10 one-hot", $countones(sw_en), 1);
      if (sw_en != 0 && sw_en != prev_sw) begin
        chk(prev_sw == 0, "R2 all-off before close", prev_sw, 0);
        if (prev_com) chk(off >= BRK, "R3 break length", off, BRK);
        if (q.size() == 0) chk(1'b0, "R5/R9 unexpected channel", $clog2(sw_en), -1);
        else begin
          int e;
          e = q.pop_front();
          chk(sw_en == (16'd1 << e), "R1/R5/R9 scoreboard", $clog2(sw_en), e);
        end
      end
      chk(busy == (com_en && sw_en == 0), "R11 busy", busy, com_en && sw_en == 0);
      off = (sw_en == 0) ? off + 1 : 0;
      prev_sw = sw_en; prev_com = com_en;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; stb = 1'b0; s_stb = 1'b0; addr = '0; s_addr = '0;
    repeat (3) @(negedge clk);
    chk(sw_en == 0 && !com_en && s_sw == 0 && !s_com, "R7 reset off", {com_en, s_com}, 0);
    q.push_back(0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(com_en && sw_en == 16'd1, "R8 wake on ch0", sw_en, 1);
    chk(s_com && s_sw == 16'd1, "R8 wake on ch0 strobe", s_sw, 1);

    cs_n = 1'b0;
    apply(5); apply(15); apply(0); apply(10);

    cs_n = 1'b1; addr = 4'd7;
    repeat (20) @(negedge clk);
    chk(sw_en == (16'd1 << 10), "R4 cs high ignores", sw_en, 16'd1 << 10);
    cs_n = 1'b0; q.push_back(7); cur = 7;
    repeat (WAIT_G) @(negedge clk);
    chk(sw_en == (16'd1 << 7), "R4 cs low accepts", sw_en, 16'd1 << 7);

    apply(7);
    chk(busy == 1'b0, "R11 idle on same address", busy, 0);

    addr = 4'd3;
    @(negedge clk);
    addr = 4'd12; q.push_back(12); cur = 12;
    repeat (WAIT_G + 1) @(negedge clk);
    chk(sw_en == (16'd1 << 12), "R5 skewed change", sw_en, 16'd1 << 12);

    addr = 4'd4;
    while (!busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R11 busy in break", busy, 1);
    addr = 4'd9; q.push_back(9); cur = 9;
    repeat (3 * WAIT_G) @(negedge clk);
    chk(sw_en == (16'd1 << 9) && !busy, "R9 restart latest", sw_en, 16'd1 << 9);

    s_addr = 4'd6;
    repeat (15) @(negedge clk);
    chk(s_sw == 16'd1, "R6 no strobe no change", s_sw, 1);
    s_stb = 1'b1;
    repeat (3) @(negedge clk);
    chk(s_busy == 1'b1, "R11 strobe busy", s_busy, 1);
    repeat (WAIT_S - 3) @(negedge clk);
    chk(s_sw == (16'd1 << 6), "R6/R12 strobe capture", s_sw, 16'd1 << 6);
    s_addr = 4'd2;
    repeat (15) @(negedge clk);
    chk(s_sw == (16'd1 << 6), "R6 strobe held high", s_sw, 16'd1 << 6);
    s_stb = 1'b0;
    repeat (15) @(negedge clk);
    chk(s_sw == (16'd1 << 6), "R6 strobe falling", s_sw, 16'd1 << 6);
    s_stb = 1'b1;
    repeat (WAIT_S) @(negedge clk);
    chk(s_sw == (16'd1 << 2), "R6 second strobe", s_sw, 16'd1 << 2);

    #2 rst_n = 1'b0;
    #1;
    chk(sw_en == 0 && !com_en && s_sw == 0 && !s_com && !busy, "R7 async reset", sw_en, 0);
    @(negedge clk);
    q.delete(); q.push_back(0); cur = 0; addr = 4'd0; s_addr = 4'd0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(com_en && sw_en == 16'd1 && s_sw == 16'd1, "R8 wake after reset", sw_en, 1);

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R1 scoreboard drained", q.size(), 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule